// File: doc/BRIEF.md
# Memory-Backed Long Serial Delay Line

This block delays a single-bit serial stream by a fixed and very large number of shift events. It does not build a chain of flip-flops. It keeps one storage bit per delay stage in an inferred memory array, and a circular index walks that array. The default depth gives 80001 locations (indices 0 through 80000). At a shift rate of 80 kHz this is roughly one second of delay.

The block runs on a fast system clock. It advances only in cycles where the shift strobe is high. One shift reads the old bit at the current location into a registered output and writes the new input bit into that same location. The index then advances and wraps back to zero after its last location. The stream has no back-pressure, and the block accepts every strobe in the cycle it is presented. Storage is packed into words of a parameterised width. Only the addressed bit of a word is written, so neighbouring bits keep their contents.

Top module: `dl_long_delay`

## Requirements
- R1: After power-up and reset, `dout` is 0. It stays 0 for the first DEPTH+1 shifts, because all storage starts at 0.
- R2: In steady state, the value of `dout` after a shift equals the `din` presented DEPTH+1 shifts earlier, counting only cycles with `shift_en` high.
- R3: Each shift advances the location index by exactly one.
- R4: A shift taken at location DEPTH moves the index to location 0, so DEPTH+1 locations are used in turn.
- R5: In a cycle with `shift_en` low, `dout`, the index and the stored bits all keep their values, whatever `din` is.
- R6: A synchronous reset clears `dout` and the index and leaves the stored bits untouched. After reset, the next DEPTH+1 shifts return the bits held at locations 0 through DEPTH, in that order.
- R7: Reset takes priority over a shift in the same cycle. That cycle writes nothing to storage and does not advance the index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of index and output |
| shift_en | input | 1 | Shift strobe; one shift per cycle it is high |
| din | input | 1 | Serial input bit, taken on a shift |
| dout | output | 1 | Registered serial output, updated only by a shift or reset |

## Verification
The assertions assume that `shift_en` and `rst` are clean synchronous levels, and that `rst` is high at the first clock edge so the index starts from a known value. The assertions place no assumption on how shifts are spaced; back-to-back strobes are legal. The stimulus holds reset from time zero and changes every input only on the falling edge. It mixes idle gaps of random length with bursts of strobes, so every cycle spacing is exercised, and it raises reset mid-stream and together with a strobe.

// File: rtl/dl_pkg.sv
package dl_pkg;

  // Number of words needed to hold a number of one-bit locations.
  function automatic int unsigned words_for(int unsigned locs, int unsigned word_w);
    return (locs + word_w - 1) / word_w;
  endfunction

  // Width of the in-word bit select; kept at least 1 so slices stay legal.
  function automatic int unsigned sel_width(int unsigned word_w);
    return (word_w > 1) ? $clog2(word_w) : 1;
  endfunction

endpackage

// File: rtl/dl_wrap_ptr.sv
module dl_wrap_ptr #(
  parameter int unsigned LAST = 80000,
  parameter int unsigned W    = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] ptr
);

  localparam logic [W-1:0] LAST_V = W'(LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      if (ptr == LAST_V) ptr <= '0;
      else               ptr <= ptr + 1'b1;
    end
  end

endmodule

// File: rtl/dl_bit_store.sv
module dl_bit_store
  import dl_pkg::*;
#(
  parameter int unsigned NUM_LOC = 80001,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned PTR_W   = 17
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] addr,
  input  logic             wbit,
  output logic             rbit
);

  localparam int unsigned NUM_WORDS = words_for(NUM_LOC, WORD_W);
  localparam int unsigned SEL_W     = sel_width(WORD_W);

  generate
    if (WORD_W == 1) begin : g_flat
      logic mem [NUM_LOC];

      initial begin
        for (int i = 0; i < int'(NUM_LOC); i++) mem[i] = 1'b0;
      end

      always_ff @(posedge clk) begin
        if (we) mem[addr] <= wbit;
      end

      assign rbit = mem[addr];
    end else begin : g_packed
      localparam int unsigned IDX_W = PTR_W - SEL_W;

      logic [WORD_W-1:0] mem [NUM_WORDS];
      logic [IDX_W-1:0]  widx;
      logic [SEL_W-1:0]  bsel;

      assign widx = addr[PTR_W-1:SEL_W];
      assign bsel = addr[SEL_W-1:0];

      initial begin
        for (int i = 0; i < int'(NUM_WORDS); i++) mem[i] = '0;
      end

      // Bit-granular write: other bits of the word keep their contents.
      always_ff @(posedge clk) begin
        if (we) mem[widx][bsel] <= wbit;
      end

      assign rbit = mem[widx][bsel];
    end
  endgenerate

endmodule

// File: rtl/dl_long_delay.sv
module dl_long_delay #(
  parameter int unsigned DEPTH  = 80000,
  parameter int unsigned WORD_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic din,
  output logic dout
);

  localparam int unsigned NUM_LOC = DEPTH + 1;
  localparam int unsigned PTR_W   = $clog2(NUM_LOC);

  logic [PTR_W-1:0] ptr_q;
  logic             step;
  logic             old_bit;

  // Reset wins over a shift: no write and no advance in a reset cycle.
  assign step = shift_en & ~rst;

  dl_wrap_ptr #(
    .LAST (DEPTH),
    .W    (PTR_W)
  ) ptr_i (
    .clk (clk),
    .rst (rst),
    .adv (step),
    .ptr (ptr_q)
  );

  dl_bit_store #(
    .NUM_LOC (NUM_LOC),
    .WORD_W  (WORD_W),
    .PTR_W   (PTR_W)
  ) store_i (
    .clk  (clk),
    .we   (step),
    .addr (ptr_q),
    .wbit (din),
    .rbit (old_bit)
  );

  // Output takes the value held before this shift's write lands.
  always_ff @(posedge clk) begin
    if (rst)       dout <= 1'b0;
    else if (step) dout <= old_bit;
  end

endmodule

// File: rtl/dl_long_delay_chk.sv
module dl_long_delay_chk #(
  parameter int unsigned DEPTH = 80000,
  parameter int unsigned PTR_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_en,
  input logic             dout,
  input logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST_V = PTR_W'(DEPTH);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && ptr != LAST_V) |=> ptr == $past(ptr) + 1'b1);

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && ptr == LAST_V) |=> ptr == '0);

  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST_V);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> ($stable(ptr) && $stable(dout)));

  // R6
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (ptr == '0 && dout == 1'b0));

endmodule

bind dl_long_delay dl_long_delay_chk #(
  .DEPTH (DEPTH),
  .PTR_W (PTR_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .shift_en (shift_en),
  .dout     (dout),
  .ptr      (ptr_q)
);

// File: tb/dl_long_delay_tb_top.sv
`timescale 1ns/1ps
module dl_long_delay_tb_top;

  localparam int unsigned DEPTH  = 8;
  localparam int unsigned WORD_W = 4;
  localparam int unsigned NLOC   = DEPTH + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0;
  logic din = 1'b0;
  logic dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference storage built from the requirements.
  bit model_mem [NLOC];
  int mptr = 0;
  bit exp_q = 1'b0;

  always #2.5 clk = ~clk;

  dl_long_delay #(.DEPTH(DEPTH), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(din), .dout(dout)
  );

  function automatic int next_loc(int p);
    return (p == int'(DEPTH)) ? 0 : p + 1;
  endfunction

  task automatic check(string tag);
    checks++;
    if (dout !== exp_q) begin
      fails++;
      $display("FAIL %s: dout=%0b expected=%0b", tag, dout, exp_q);
    end
  endtask

  // One clock cycle: drive on the falling edge, update model, check on next falling edge.
  task automatic cycle(bit r, bit s, bit d, string tag);
    rst = r; shift_en = s; din = d;
    @(posedge clk);
    if (r) begin
      exp_q = 1'b0;
      mptr  = 0;
    end else if (s) begin
      exp_q = model_mem[mptr];
      model_mem[mptr] = d;
      mptr = next_loc(mptr);
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < int'(NLOC); i++) model_mem[i] = 1'b0;
    @(negedge clk);
    cycle(1'b1, 1'b0, 1'b0, "R6 reset state");
    cycle(1'b1, 1'b1, 1'b1, "R7 reset with shift");

    // R1: all-ones input, output stays 0 for DEPTH+1 shifts.
    for (int i = 0; i < int'(NLOC); i++) cycle(1'b0, 1'b1, 1'b1, "R1 power-up zeros");
    // R2: ones come back exactly DEPTH+1 shifts later.
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 1'b0, "R2 delayed ones");

    // R5: idle cycles with toggling din change nothing.
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, bit'(i[0]), "R5 idle hold");

    // Alternating pattern over several wraps (R3, R4).
    for (int i = 0; i < 5 * int'(NLOC); i++) cycle(1'b0, 1'b1, bit'(i[0]), "R4 wrap pattern");

    // Random stream with random gaps (R2, R3, R5).
    for (int i = 0; i < 3000; i++) begin
      bit s = ($urandom % 3) != 0;
      cycle(1'b0, s, bit'($urandom), s ? "R2 random stream" : "R5 random gap");
    end

    // Mid-stream reset: storage retained, replay from location 0 (R6).
    cycle(1'b1, 1'b0, 1'b0, "R6 mid reset");
    for (int i = 0; i < int'(NLOC); i++) cycle(1'b0, 1'b1, bit'($urandom), "R6 replay after reset");

    // Reset plus shift: no write, no advance (R7).
    cycle(1'b1, 1'b1, 1'b1, "R7 reset priority");
    cycle(1'b1, 1'b1, 1'b0, "R7 reset priority");
    for (int i = 0; i < 2 * int'(NLOC); i++) cycle(1'b0, 1'b1, bit'($urandom), "R7 after reset");

    // Back-to-back strobes after long idle (R3).
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 1'b1, "R5 long idle");
    for (int i = 0; i < 3 * int'(NLOC); i++) cycle(1'b0, 1'b1, bit'($urandom), "R3 burst");

    finish_run();
  end

endmodule